// File: doc/BRIEF.md
# GPIO Interrupt Capture Unit

This block is a general-purpose I/O unit. It has a set of interrupt-capable bidirectional pins and a further group of output-only pins. Software reaches it over a 16-bit register bus. Each 32-bit register is split into two halfword slots: the even slot holds bits 15:0 and the odd slot holds bits 31:16.

For each interrupt-capable pin, software chooses:
- the direction;
- the output value;
- edge or level triggering;
- active-high or active-low for level triggers;
- whether an event is latched until cleared or is reported live.

Input pins pass through a two-flop synchronizer before any event logic. Every pin that sees an event sets a status bit. A per-pin enable mask gates the status bits into one registered interrupt line that goes to an upstream controller.

The bus is plain control: a single-cycle write strobe with address and data, and a combinational read port that always shows the halfword at the current address. The block carries no streaming data, so it needs no valid/ready flow control.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register is 0. All pins are inputs, all interrupts are masked, `pin_oe` is 0 and `irq` is low.
- R2: `bus_addr[3:1]` selects the register and `bus_addr[0]` selects the half (0 = bits 15:0, 1 = bits 31:16). The register selects are:
  - 0: direction
  - 1: data for pins 0..31
  - 2: data for output-only pins
  - 3: status
  - 4: enable
  - 5: trigger type
  - 6: level polarity
  - 7: hold select
- R3: A direction bit of 1 makes that pin an output: `pin_oe` is 1 and `pin_out` carries the written data bit. Reading register 1 returns the written bit for output pins and the synchronized pin level for input pins. A pin change appears in the read value on the second clock edge after it.
- R4: Output-only pin k is bit k of register 2 and drives `aux_out[k]`. Bits of register 2 above the output-only pin count read 0.
- R5: `irq` is the OR of status AND enable, registered, so it follows status by one cycle. Status bits are still recorded for masked pins.
- R6: A trigger-type bit of 1 selects edge triggering. An event is a rising edge of the synchronized level, the polarity bit is ignored, and a level held high raises no further event.
- R7: A trigger-type bit of 0 selects level triggering. A polarity bit of 1 makes a high level active; a polarity bit of 0 makes a low level active.
- R8: A hold bit of 1 keeps a status bit set until software clears it. A hold bit of 0 makes the status bit follow the live event condition, one cycle late.
- R9: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. If a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: A pin whose direction bit is 1 never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Halfword write strobe, one cycle per write |
| bus_addr | input | 4 | Halfword address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| pin_in | input | 32 | Pin levels, asynchronous to clk |
| pin_out | output | 32 | Output data for interrupt-capable pins |
| pin_oe | output | 32 | Output enable (1 = driven) |
| aux_out | output | 16 | Output-only pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pin_in` may change in any cycle, since it enters through the synchronizer. They also assume that every 4-bit address is a legal register half, so the properties make no assumption about the address pattern. The stimulus changes every input a quarter-step after the falling edge. Writes are single-cycle strobes to arbitrary halves, including status clears that land in the same cycle as fresh edges. This covers the set-versus-clear collision and the live and held modes, and it never relies on a forbidden input pattern.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic [2:0] {
    RS_DIR    = 3'd0,
    RS_DATA_A = 3'd1,
    RS_DATA_B = 3'd2,
    RS_STAT   = 3'd3,
    RS_EN     = 3'd4,
    RS_TRIG   = 3'd5,
    RS_POL    = 3'd6,
    RS_HOLD   = 3'd7
  } reg_sel_e;

  function automatic word_t put_half(word_t old, logic upper, half_t d);
    put_half = upper ? {d, old[HALF_W-1:0]} : {old[WORD_W-1:HALF_W], d};
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] level_prev
);
  logic [WIDTH-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign level      = lvl_q;
  assign level_prev = prev_q;
endmodule

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic lvl_now,
  input  logic lvl_prev,
  input  logic is_output,
  input  logic edge_mode,
  input  logic active_high,
  input  logic hold_mode,
  input  logic sw_clear,
  output logic stat
);
  logic rise, lvl_active, event_now, stat_q;

  always_comb begin
    rise       = lvl_now & ~lvl_prev;
    lvl_active = active_high ? lvl_now : ~lvl_now;
    event_now  = ~is_output & (edge_mode ? rise : lvl_active);
  end

  always_ff @(posedge clk) begin
    if (rst)            stat_q <= 1'b0;
    else if (hold_mode) stat_q <= (stat_q & ~sw_clear) | event_now;
    else                stat_q <= event_now;
  end

  assign stat = stat_q;

  // R8: a held bit with no clear stays set
  a_r8_hold_sticky: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && stat_q && !sw_clear) |=> stat_q);
  // R9: an event in the same cycle as a clear still sets the bit
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && event_now && sw_clear) |=> stat_q);
  // R9: a clear with no event empties the bit
  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && sw_clear && !event_now) |=> !stat_q);
  // R6: a steady high level in live edge mode reports nothing
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && !hold_mode && lvl_now && lvl_prev) |=> !stat_q);
  // R10: an output pin in live mode never reports
  a_r10_output_quiet: assert property (@(posedge clk) disable iff (rst)
    (is_output && !hold_mode) |=> !stat_q);
endmodule

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int IRQ_PINS      = 32,
  parameter int OUT_ONLY_PINS = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bus_wr,
  input  logic  [3:0] bus_addr,
  input  half_t bus_wdata,
  output half_t bus_rdata,
  input  word_t pin_level,
  input  word_t stat,
  output word_t dir,
  output word_t data_a,
  output word_t data_b,
  output word_t en,
  output word_t trig,
  output word_t pol,
  output word_t hold,
  output word_t clr
);
  localparam logic [WORD_W:0] ONE       = 1;
  localparam word_t           PIN_MASK  = word_t'((ONE << IRQ_PINS) - 1);
  localparam word_t           AUX_MASK  = word_t'((ONE << OUT_ONLY_PINS) - 1);

  reg_sel_e sel;
  logic     upper;
  word_t    rd_word;

  assign sel   = reg_sel_e'(bus_addr[3:1]);
  assign upper = bus_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir    <= '0;
      data_a <= '0;
      data_b <= '0;
      en     <= '0;
      trig   <= '0;
      pol    <= '0;
      hold   <= '0;
    end else if (bus_wr) begin
      case (sel)
        RS_DIR:    dir    <= put_half(dir,    upper, bus_wdata) & PIN_MASK;
        RS_DATA_A: data_a <= put_half(data_a, upper, bus_wdata) & PIN_MASK;
        RS_DATA_B: data_b <= put_half(data_b, upper, bus_wdata) & AUX_MASK;
        RS_EN:     en     <= put_half(en,     upper, bus_wdata) & PIN_MASK;
        RS_TRIG:   trig   <= put_half(trig,   upper, bus_wdata) & PIN_MASK;
        RS_POL:    pol    <= put_half(pol,    upper, bus_wdata) & PIN_MASK;
        RS_HOLD:   hold   <= put_half(hold,   upper, bus_wdata) & PIN_MASK;
        default:   ;
      endcase
    end
  end

  always_comb begin
    clr = '0;
    if (bus_wr && sel == RS_STAT)
      clr = put_half('0, upper, bus_wdata) & PIN_MASK;
  end

  always_comb begin
    case (sel)
      RS_DIR:    rd_word = dir;
      RS_DATA_A: rd_word = (dir & data_a) | (~dir & pin_level & PIN_MASK);
      RS_DATA_B: rd_word = data_b;
      RS_STAT:   rd_word = stat & PIN_MASK;
      RS_EN:     rd_word = en;
      RS_TRIG:   rd_word = trig;
      RS_POL:    rd_word = pol;
      default:   rd_word = hold;
    endcase
    bus_rdata = upper ? rd_word[WORD_W-1:HALF_W] : rd_word[HALF_W-1:0];
  end

  // R4: output-only bits above the pin count stay empty
  a_r4_aux_clean: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((data_b & ~AUX_MASK) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int IRQ_PINS      = 32,
  parameter int OUT_ONLY_PINS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [3:0]               bus_addr,
  input  logic [15:0]              bus_wdata,
  output logic [15:0]              bus_rdata,
  input  logic [IRQ_PINS-1:0]      pin_in,
  output logic [IRQ_PINS-1:0]      pin_out,
  output logic [IRQ_PINS-1:0]      pin_oe,
  output logic [OUT_ONLY_PINS-1:0] aux_out,
  output logic                     irq
);
  logic [IRQ_PINS-1:0] lvl, lvl_prev, stat_v;
  word_t dir_w, data_a_w, data_b_w, en_w, trig_w, pol_w, hold_w, clr_w;
  logic  irq_q;

  gpio_irq_sync #(.WIDTH(IRQ_PINS)) sync_i (
    .clk(clk), .rst(rst), .raw(pin_in), .level(lvl), .level_prev(lvl_prev)
  );

  gpio_irq_regfile #(.IRQ_PINS(IRQ_PINS), .OUT_ONLY_PINS(OUT_ONLY_PINS)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_level(word_t'(lvl)), .stat(word_t'(stat_v)),
    .dir(dir_w), .data_a(data_a_w), .data_b(data_b_w), .en(en_w),
    .trig(trig_w), .pol(pol_w), .hold(hold_w), .clr(clr_w)
  );

  for (genvar p = 0; p < IRQ_PINS; p++) begin : g_pin
    gpio_irq_pin_cell cell_i (
      .clk(clk), .rst(rst),
      .lvl_now(lvl[p]), .lvl_prev(lvl_prev[p]),
      .is_output(dir_w[p]), .edge_mode(trig_w[p]),
      .active_high(pol_w[p]), .hold_mode(hold_w[p]),
      .sw_clear(clr_w[p]), .stat(stat_v[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_v & en_w[IRQ_PINS-1:0]);
  end

  assign irq     = irq_q;
  assign pin_out = data_a_w[IRQ_PINS-1:0];
  assign pin_oe  = dir_w[IRQ_PINS-1:0];
  assign aux_out = data_b_w[OUT_ONLY_PINS-1:0];

  // R5: no enabled status means no request next cycle
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((stat_v & en_w[IRQ_PINS-1:0]) == '0) |=> !irq_q);
  // R5: an enabled status raises the request next cycle
  a_r5_raise: assert property (@(posedge clk) disable iff (rst)
    (|(stat_v & en_w[IRQ_PINS-1:0])) |=> irq_q);
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [15:0] aux_out;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .aux_out(aux_out), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_s1, m_s2, m_s3, m_dir, m_da, m_db, m_st, m_en, m_ty, m_po, m_ho;
  bit          m_irq;

  function automatic logic [31:0] ph(logic [31:0] old, bit up, logic [15:0] d);
    return up ? {d, old[15:0]} : {old[31:16], d};
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] rise_v, act_v, ev_v, clr_v;
    bit nxt_irq;
    if (rst) begin
      {m_s1, m_s2, m_s3, m_dir, m_da, m_db, m_st, m_en, m_ty, m_po, m_ho} = '0;
      m_irq = 1'b0;
    end else begin
      rise_v = m_s2 & ~m_s3;
      act_v  = (m_s2 & m_po) | (~m_s2 & ~m_po);
      ev_v   = ~m_dir & ((m_ty & rise_v) | (~m_ty & act_v));
      clr_v  = '0;
      if (bus_wr && bus_addr[3:1] == 3'd3) clr_v = ph('0, bus_addr[0], bus_wdata);
      nxt_irq = |(m_st & m_en);
      m_st  = (m_ho & ((m_st & ~clr_v) | ev_v)) | (~m_ho & ev_v);
      m_irq = nxt_irq;
      if (bus_wr) begin
        case (bus_addr[3:1])
          3'd0: m_dir = ph(m_dir, bus_addr[0], bus_wdata);
          3'd1: m_da  = ph(m_da,  bus_addr[0], bus_wdata);
          3'd2: m_db  = ph(m_db,  bus_addr[0], bus_wdata) & 32'h0000FFFF;
          3'd4: m_en  = ph(m_en,  bus_addr[0], bus_wdata);
          3'd5: m_ty  = ph(m_ty,  bus_addr[0], bus_wdata);
          3'd6: m_po  = ph(m_po,  bus_addr[0], bus_wdata);
          3'd7: m_ho  = ph(m_ho,  bus_addr[0], bus_wdata);
          default: ;
        endcase
      end
      m_s3 = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  function automatic logic [15:0] model_read(logic [3:0] a);
    logic [31:0] w;
    case (a[3:1])
      3'd0: w = m_dir;
      3'd1: w = (m_dir & m_da) | (~m_dir & m_s2);
      3'd2: w = m_db;
      3'd3: w = m_st;
      3'd4: w = m_en;
      3'd5: w = m_ty;
      3'd6: w = m_po;
      default: w = m_ho;
    endcase
    return a[0] ? w[31:16] : w[15:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_addr[3:1] == 3'd3 ? "R9 status read" : "R2 register read",
          32'(bus_rdata), 32'(model_read(bus_addr)));
      chk("R5 irq", 32'(irq), 32'(m_irq));
      chk("R3 pin_out", pin_out, m_da);
      chk("R3 pin_oe", pin_oe, m_dir);
      chk("R4 aux_out", 32'(aux_out), m_db);
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic pins(logic [31:0] v);
    @(negedge clk); #1;
    pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq low", 32'(irq), 0);
    chk("R1 pin_oe clear", pin_oe, 0);
    rd(4'd8, 16'h0000, "R1 enable clear");

    // R3 direction and data readback
    wr(4'd0, 16'h00F0);
    wr(4'd2, 16'h00A5);
    idle(4);
    chk("R3 pin_out value", pin_out, 32'h0000_00A5);
    chk("R3 pin_oe value", pin_oe, 32'h0000_00F0);
    rd(4'd2, 16'h00A0, "R3 mixed readback low");
    pins(32'h0000_000F);
    idle(4);
    rd(4'd2, 16'h00AF, "R3 input levels readback");
    pins(32'h0);
    idle(4);

    // R4 output-only pins
    wr(4'd4, 16'hBEEF);
    idle(1);
    chk("R4 aux pins", 32'(aux_out), 32'h0000_BEEF);
    rd(4'd5, 16'h0000, "R4 upper half empty");

    // R5 / R10 masked recording, outputs silent
    rd(4'd6, 16'hFF0F, "R5 masked status recorded, R10 outputs silent");
    chk("R5 irq masked", 32'(irq), 0);

    // R6 / R8 / R9 edge hold on pin 0
    wr(4'd10, 16'h0001);
    wr(4'd14, 16'h0001);
    wr(4'd6, 16'hFFFF);
    idle(3);
    rd(4'd6, 16'hFF0E, "R6 no edge no event");
    wr(4'd8, 16'h0001);
    idle(3);
    chk("R6 idle edge pin", 32'(irq), 0);
    pins(32'h1);
    idle(6);
    chk("R6 rising edge", 32'(irq), 1);
    pins(32'h0);
    idle(6);
    chk("R8 held after fall", 32'(irq), 1);
    wr(4'd6, 16'h0000);
    idle(3);
    chk("R9 write zero keeps", 32'(irq), 1);
    wr(4'd6, 16'h0001);
    idle(3);
    chk("R9 write one clears", 32'(irq), 0);
    pins(32'h1);
    idle(6);
    chk("R6 second edge", 32'(irq), 1);
    wr(4'd6, 16'h0001);
    idle(6);
    chk("R6 steady high no retrigger", 32'(irq), 0);
    pins(32'h0);
    idle(4);

    // R7 / R8 level active-high, live on pin 1
    wr(4'd12, 16'h0002);
    wr(4'd8, 16'h0002);
    idle(6);
    chk("R7 high-active idle low", 32'(irq), 0);
    pins(32'h2);
    idle(6);
    chk("R7 high-active asserted", 32'(irq), 1);
    pins(32'h0);
    idle(6);
    chk("R8 live follows release", 32'(irq), 0);

    // R10 output pin produces no event until made an input
    wr(4'd8, 16'h0010);
    idle(6);
    chk("R10 output pin silent", 32'(irq), 0);
    wr(4'd0, 16'h0000);
    idle(6);
    chk("R10 input pin low-active fires", 32'(irq), 1);

    // random phase, compared against the model every clock (R9 collisions included)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      bus_wr    = ($urandom % 3) == 0;
      bus_addr  = 4'($urandom);
      bus_wdata = 16'($urandom);
      if (($urandom % 4) == 0) pin_in = $urandom;
    end
    @(negedge clk); #1;
    bus_wr = 1'b0;
    idle(4);
    finish_run();
  end
endmodule